// File: doc/BRIEF.md
# Store-and-Forward Packet Stream Buffer

This block sits between a packet producer and a packet consumer on a 64-bit AXI4-Stream link. It holds back each packet until every beat of it, up to and including the beat that carries TLAST, has been written into its internal RAM. Only then does it offer the packet on its output side. Once a packet has started leaving, the buffer drives TVALID high on every cycle until that packet's final beat. A consumer that cannot tolerate idle cycles inside a packet is therefore never starved, even when the producer sends in bursts with gaps.

The write side also serves producers that ignore TREADY. Any beat presented while space remains is stored. If the RAM fills before a packet's closing beat arrives, the partial packet is erased by moving the write pointer back to the last packet boundary. The rest of that packet is discarded up to its closing beat, and a sticky overflow flag is raised. Packets stored earlier are not affected. Each stored entry holds TDATA, TKEEP and TLAST side by side, so the output beats are bit-identical to the input beats and leave in the same order.

Top module: `pkt_sf_fifo`

## Requirements
- R1: One clock edge after reset has been sampled low, mValid and overflow are 0 and sReady is 1.
- R2: mValid stays 0 until the beat with sLast=1 of a packet has been captured. Data from a partly written packet is never offered.
- R3: After the first beat of a packet has transferred on the output, mValid stays 1 on every following cycle until the beat with mLast=1 transfers, whatever the value of mReady.
- R4: Every output beat equals the matching input beat in all 64 data bits, all 8 keep bits and the last bit. Beats leave in arrival order, and they hold steady while mValid=1 and mReady=0.
- R5: Idle cycles (sValid=0) inside an input packet neither split nor corrupt it. Data and sLast presented while sValid=0 are ignored.
- R6: sReady is 0 exactly when the RAM is full and no packet is being discarded. A beat presented when full erases the partial packet, sets overflow, and causes the packet's remaining beats to be discarded through its sLast beat. Packets completed earlier still leave intact, and the next packet is stored normally.
- R7: A packet longer than the RAM depth never appears on the output and sets overflow.
- R8: When one packet completes on the input in the same cycle that another finishes on the output, both are accounted for. Several queued packets leave back to back with no idle cycle between them.
- R9: Once set, overflow stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| sData | input | DATA_W | Input beat data |
| sKeep | input | DATA_W/8 | Input byte-valid mask |
| sLast | input | 1 | Input beat closes its packet |
| sValid | input | 1 | Input beat present |
| sReady | output | 1 | Space available (or discarding) |
| mData | output | DATA_W | Output beat data |
| mKeep | output | DATA_W/8 | Output byte-valid mask |
| mLast | output | 1 | Output beat closes its packet |
| mValid | output | 1 | Output beat present |
| mReady | input | 1 | Consumer takes the beat |
| overflow | output | 1 | Sticky: a partial packet was dropped |

## Verification
Two events can fall in the same cycle: a packet completing on the input, which adds to the stored-packet count, and a packet finishing on the output, which subtracts from it. A second case is an overflow rewind during an active read. The bench provokes the first by streaming single-beat packets back to back with the consumer always ready, and by writing new packets while queued ones drain. It provokes the second by overflowing while an earlier packet sits waiting. Results are judged at the output ports. A scoreboard of arithmetically generated beats must match every transferred beat exactly. The bench also counts unbroken valid cycles across queued packets, and it checks that nothing extra or missing comes out.

// File: rtl/pkt_sf_pkg.sv
package pkt_sf_pkg;

  // Strobes from the control half to the storage half.
  typedef struct packed {
    logic wrEn;   // store the presented beat at the write address
  } memStrobe_t;

endpackage

// File: rtl/pkt_sf_mem.sv
module pkt_sf_mem
  import pkt_sf_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int DEPTH_LOG2 = 4
) (
  input  logic                  clk,
  input  memStrobe_t            strobe,
  input  logic [DEPTH_LOG2-1:0] wrAddr,
  input  logic [DEPTH_LOG2-1:0] rdAddr,
  input  logic [DATA_W-1:0]     inData,
  input  logic [DATA_W/8-1:0]   inKeep,
  input  logic                  inLast,
  output logic [DATA_W-1:0]     outData,
  output logic [DATA_W/8-1:0]   outKeep,
  output logic                  outLast
);
  localparam int KEEP_W  = DATA_W / 8;
  localparam int DEPTH   = 1 << DEPTH_LOG2;
  localparam int ENTRY_W = DATA_W + KEEP_W + 1;

  logic [ENTRY_W-1:0] store [DEPTH];
  logic [ENTRY_W-1:0] rdEntry;

  always_ff @(posedge clk) begin
    if (strobe.wrEn) store[wrAddr] <= {inLast, inKeep, inData};
  end

  // Combinational read: the head entry is visible while it waits.
  assign rdEntry = store[rdAddr];
  assign outData = rdEntry[DATA_W-1:0];
  assign outKeep = rdEntry[DATA_W +: KEEP_W];
  assign outLast = rdEntry[ENTRY_W-1];

endmodule

// File: rtl/pkt_sf_ctrl.sv
module pkt_sf_ctrl
  import pkt_sf_pkg::*;
#(
  parameter int DEPTH_LOG2 = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  input  logic                  inLast,
  output logic                  inReady,
  input  logic                  outReady,
  input  logic                  headLast,
  output logic                  outValid,
  output logic                  overflow,
  output memStrobe_t            strobe,
  output logic [DEPTH_LOG2-1:0] wrAddr,
  output logic [DEPTH_LOG2-1:0] rdAddr
);
  localparam int DEPTH = 1 << DEPTH_LOG2;
  localparam int PTR_W = DEPTH_LOG2 + 1;

  logic [PTR_W-1:0] wrPtr, commitPtr, rdPtr, pktCount, used;
  logic dropping, full, accept, overEvt, commitEvt, releaseEvt, outFire;

  assign used       = wrPtr - rdPtr;
  assign full       = (used == PTR_W'(DEPTH));
  assign accept     = inValid && !dropping && !full;
  assign overEvt    = inValid && !dropping && full;
  assign commitEvt  = accept && inLast;
  assign outValid   = (pktCount != '0);
  assign outFire    = outValid && outReady;
  assign releaseEvt = outFire && headLast;
  assign inReady    = dropping || !full;

  assign strobe.wrEn = accept;
  assign wrAddr      = wrPtr[DEPTH_LOG2-1:0];
  assign rdAddr      = rdPtr[DEPTH_LOG2-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      commitPtr <= '0;
      rdPtr     <= '0;
      pktCount  <= '0;
      dropping  <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      if (accept) begin
        wrPtr <= wrPtr + 1'b1;
        if (inLast) commitPtr <= wrPtr + 1'b1;
      end
      if (overEvt) begin
        wrPtr    <= commitPtr;   // erase the partial packet
        overflow <= 1'b1;
        dropping <= !inLast;     // discard the tail unless this beat closed it
      end
      if (dropping && inValid && inLast) dropping <= 1'b0;
      if (outFire) rdPtr <= rdPtr + 1'b1;
      unique case ({commitEvt, releaseEvt})
        2'b10:   pktCount <= pktCount + 1'b1;
        2'b01:   pktCount <= pktCount - 1'b1;
        default: pktCount <= pktCount;
      endcase
    end
  end

endmodule

// File: rtl/pkt_sf_fifo.sv
module pkt_sf_fifo
  import pkt_sf_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int DEPTH_LOG2 = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [DATA_W-1:0]   sData,
  input  logic [DATA_W/8-1:0] sKeep,
  input  logic                sLast,
  input  logic                sValid,
  output logic                sReady,
  output logic [DATA_W-1:0]   mData,
  output logic [DATA_W/8-1:0] mKeep,
  output logic                mLast,
  output logic                mValid,
  input  logic                mReady,
  output logic                overflow
);
  memStrobe_t            strobe;
  logic [DEPTH_LOG2-1:0] wrAddr, rdAddr;

  pkt_sf_ctrl #(.DEPTH_LOG2(DEPTH_LOG2)) ctrlI (
    .clk(clk), .rstN(rstN),
    .inValid(sValid), .inLast(sLast), .inReady(sReady),
    .outReady(mReady), .headLast(mLast), .outValid(mValid),
    .overflow(overflow), .strobe(strobe),
    .wrAddr(wrAddr), .rdAddr(rdAddr)
  );

  pkt_sf_mem #(.DATA_W(DATA_W), .DEPTH_LOG2(DEPTH_LOG2)) memI (
    .clk(clk), .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .inData(sData), .inKeep(sKeep), .inLast(sLast),
    .outData(mData), .outKeep(mKeep), .outLast(mLast)
  );

endmodule

// File: rtl/pkt_sf_fifo_chk.sv
module pkt_sf_fifo_chk #(
  parameter int DATA_W = 64
) (
  input logic                clk,
  input logic                rstN,
  input logic                sValid,
  input logic                sReady,
  input logic [DATA_W-1:0]   mData,
  input logic [DATA_W/8-1:0] mKeep,
  input logic                mLast,
  input logic                mValid,
  input logic                mReady,
  input logic                overflow
);

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rstN |=> (!mValid && !overflow && sReady));

  assert_no_bubble_R3: assert property (@(posedge clk) disable iff (!rstN)
    (mValid && !(mReady && mLast)) |=> mValid);

  assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    (mValid && !mReady) |=> $stable({mLast, mKeep, mData}));

  assert_overflow_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> $past(sValid && !sReady));

  assert_overflow_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

endmodule

bind pkt_sf_fifo pkt_sf_fifo_chk #(.DATA_W(DATA_W)) chkI (
  .clk(clk), .rstN(rstN), .sValid(sValid), .sReady(sReady),
  .mData(mData), .mKeep(mKeep), .mLast(mLast), .mValid(mValid),
  .mReady(mReady), .overflow(overflow)
);

// File: tb/pkt_sf_fifo_tb_top.sv
module pkt_sf_fifo_tb_top;
  localparam int DATA_W = 64;
  localparam int KEEP_W = 8;
  localparam int DEPTH_LOG2 = 3;
  localparam int BEAT_W = DATA_W + KEEP_W + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [DATA_W-1:0] sData = '0;
  logic [KEEP_W-1:0] sKeep = '0;
  logic sLast = 1'b0, sValid = 1'b0, sReady;
  logic [DATA_W-1:0] mData;
  logic [KEEP_W-1:0] mKeep;
  logic mLast, mValid, overflow;
  logic mReady = 1'b0;

  always #5 clk = ~clk;

  pkt_sf_fifo #(.DATA_W(DATA_W), .DEPTH_LOG2(DEPTH_LOG2)) dut_i (
    .clk(clk), .rstN(rstN), .sData(sData), .sKeep(sKeep), .sLast(sLast),
    .sValid(sValid), .sReady(sReady), .mData(mData), .mKeep(mKeep),
    .mLast(mLast), .mValid(mValid), .mReady(mReady), .overflow(overflow)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit inPkt = 1'b0;
  logic [BEAT_W-1:0] expQ[$];
  int base = 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [BEAT_W-1:0] mkBeat(int b, int i, int len, bit closes);
    logic [DATA_W-1:0] d;
    logic [KEEP_W-1:0] k;
    d = {32'(b) * 32'h9E37_79B9, 32'(i * 7 + 1)} ^ 64'hA5A5_0F0F_3C3C_5A5A;
    k = closes ? (8'hFF >> ((b + len) % 8)) : 8'hFF;
    return {closes, k, d};
  endfunction

  // Output monitor: scoreboard (R4) and bubble watch (R3).
  always @(negedge clk) begin
    if (!rstN) inPkt = 1'b0;
    else begin
      if (inPkt) chk(mValid, "R3", "valid dropped inside packet", mValid, 1);
      if (mValid && mReady) begin
        if (expQ.size() == 0) chk(1'b0, "R4", "unexpected beat", {mLast, mKeep, mData}, 0);
        else begin
          logic [BEAT_W-1:0] e;
          e = expQ.pop_front();
          chk({mLast, mKeep, mData} == e, "R4", "beat mismatch", {mLast, mKeep, mData}, e);
        end
        inPkt = !mLast;
      end
    end
  end

  task automatic doReset();
    rstN = 1'b0; sValid = 1'b0; mReady = 1'b0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    expQ.delete();
  endtask

  task automatic sendPkt(input int len, input int gapPat, input int b,
                         input bit kept, input bit closes, input bit quiet);
    if (kept)
      for (int i = 0; i < len; i++) expQ.push_back(mkBeat(b, i, len, closes && i == len - 1));
    for (int i = 0; i < len; i++) begin
      @(posedge clk); #1;
      sValid = 1'b1;
      {sLast, sKeep, sData} = mkBeat(b, i, len, closes && i == len - 1);
      @(negedge clk);
      if (quiet) chk(!mValid, "R2", "valid before closing beat", mValid, 0);
      if (i < len - 1) begin
        for (int g = 0; g < (gapPat * (i + 1)) % 3; g++) begin
          @(posedge clk); #1;
          sValid = 1'b0; sLast = 1'b1; sData = ~sData;   // R5 junk while idle
          @(negedge clk);
          if (quiet) chk(!mValid, "R2", "valid during input gap", mValid, 0);
        end
      end
    end
    @(posedge clk); #1;
    sValid = 1'b0; sLast = 1'b0;
  endtask

  task automatic drain(input string req);
    @(posedge clk); #1 mReady = 1'b1;
    repeat (24) @(posedge clk);
    @(negedge clk);
    chk(expQ.size() == 0, req, "beats left undelivered", expQ.size(), 0);
    chk(!mValid, req, "valid after drain", mValid, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    doReset();
    @(negedge clk);
    chk(!mValid, "R1", "reset mValid", mValid, 0);
    chk(!overflow, "R1", "reset overflow", overflow, 0);
    chk(sReady, "R1", "reset sReady", sReady, 1);

    // R2/R5 sweep: every fitting length with several gap patterns.
    mReady = 1'b1;
    for (int len = 1; len <= 8; len++)
      for (int gp = 0; gp < 3; gp++) begin
        sendPkt(len, gp, base++, 1'b1, 1'b1, 1'b1);
        drain("R5");
      end

    // R3/R4 under back-pressure: two queued packets, patterned mReady.
    for (int len = 1; len <= 4; len++) begin
      @(posedge clk); #1 mReady = 1'b0;
      sendPkt(len, 1, base++, 1'b1, 1'b1, 1'b0);
      sendPkt(len, 2, base++, 1'b1, 1'b1, 1'b0);
      for (int c = 0; c < 40; c++) begin
        @(posedge clk); #1 mReady = ((c * 5 + len) % 7) != 3;
      end
      drain("R4");
    end

    // R8: three queued packets leave without a gap.
    @(posedge clk); #1 mReady = 1'b0;
    sendPkt(3, 0, base++, 1'b1, 1'b1, 1'b0);
    sendPkt(3, 1, base++, 1'b1, 1'b1, 1'b0);
    sendPkt(2, 0, base++, 1'b1, 1'b1, 1'b0);
    @(posedge clk); #1 mReady = 1'b1;
    begin
      int run = 0;
      for (int c = 0; c < 8; c++) begin
        @(negedge clk);
        if (mValid) run++;
      end
      chk(run == 8, "R8", "unbroken valid cycles across packets", run, 8);
    end
    drain("R8");
    // R8: single-beat packets back to back, commit and release coincide.
    for (int n = 0; n < 6; n++) sendPkt(1, 0, base++, 1'b1, 1'b1, 1'b0);
    drain("R8");
    for (int n = 0; n < 4; n++) sendPkt(2, 0, base++, 1'b1, 1'b1, 1'b0);
    drain("R8");

    // R7: oversize packet is dropped.
    sendPkt(9, 0, base++, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    chk(overflow, "R7", "overflow after oversize packet", overflow, 1);
    drain("R7");
    sendPkt(2, 1, base++, 1'b1, 1'b1, 1'b1);
    drain("R7");
    chk(overflow, "R9", "overflow kept", overflow, 1);

    doReset();
    @(negedge clk);
    chk(!overflow, "R1", "overflow cleared by reset", overflow, 0);

    // R6: full with a partial packet, then a beat that overflows.
    sendPkt(5, 1, base++, 1'b1, 1'b1, 1'b0);
    sendPkt(3, 0, base++, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    chk(!sReady, "R6", "sReady when full", sReady, 0);
    chk(!overflow, "R6", "no overflow yet", overflow, 0);
    sendPkt(2, 0, base++, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    chk(overflow, "R6", "overflow after full beat", overflow, 1);
    chk(sReady, "R6", "space back after rewind", sReady, 1);
    drain("R6");
    sendPkt(3, 2, base++, 1'b1, 1'b1, 1'b1);
    drain("R6");
    chk(overflow, "R9", "overflow still set", overflow, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule